// File: doc/BRIEF.md
# USB Device Status Register File

This block is the small register file that a processor uses to supervise a full-speed USB device engine. It sits on a 16-bit memory-mapped bus and exposes three words: a control and status word, the frame number of the most recent start-of-frame token, and the device address that the host has assigned. The USB engine drives it with single-cycle event pulses: start-of-frame together with its 11-bit frame number, bus reset, and bus activity.

Firmware polls the control and status word to learn what happened on the bus since the last look. The start-of-frame and activity flags clear themselves when that word is read. The bus-reset flag stays set until firmware acknowledges it by writing a zero. An idle timer runs alongside the registers and raises a suspend request once the bus has been quiet for a configurable time, 3 ms by default. The enable bit and the device address are also driven out as plain outputs for the rest of the engine.

Top module: `usbdev_regs`

## Requirements
- R1: After synchronous reset every register reads 0x0000, `usb_enable` is 0, `dev_addr` is 0 and `suspend_req` is 0.
- R2: The control word at BASE_ADDR packs its fields as bit 0 = enable, bit 1 = reset-seen, bit 2 = SOF-seen and bit 3 = activity-seen. Bit 0 can be written and drives `usb_enable`. Bits 15..4 always read as 0, even after a write of ones.
- R3: An `sof_pulse` sets bit 2 of the control word and loads `sof_frame` into bits 10..0 of the frame word at BASE_ADDR+2. Bits 15..11 of the frame word read as 0.
- R4: `cpu_rdata` presents the selected register in the cycle after a `cpu_rd` strobe. A read of any other address returns 0x0000.
- R5: Reading the control word returns the flags as they stood before the read, then clears bits 2 and 3.
- R6: When an event pulse arrives in the same cycle as an access that would clear its flag, the flag ends up set.
- R7: A `busrst_pulse` sets bit 1 of the control word. Bit 1 is not cleared by a read. Writing 0 to bit 1 clears it, and writing 1 to it has no effect.
- R8: The frame word is read-only: writes to BASE_ADDR+2 change nothing.
- R9: The address word at BASE_ADDR+4 holds the device address in bits 6..0, which can be read and written and drive `dev_addr`. Bits 15..7 read as 0.
- R10: A `busrst_pulse` clears the device address to 0. It leaves the enable bit unchanged.
- R11: `suspend_req` rises after IDLE_CYCLES consecutive clock cycles without `activity_stb`, where IDLE_CYCLES = CLK_KHZ*IDLE_US/1000. It stays high until an activity strobe and is low in the cycle after that strobe.
- R12: An `activity_stb` sets bit 3 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, registered |
| sof_pulse | input | 1 | Start-of-frame received |
| sof_frame | input | 11 | Frame number carried by the SOF |
| busrst_pulse | input | 1 | USB bus reset detected |
| activity_stb | input | 1 | Bus activity seen |
| usb_enable | output | 1 | Enable bit of the control word |
| dev_addr | output | 7 | Assigned device address |
| suspend_req | output | 1 | Bus idle long enough to suspend |

## Verification
Two things can land in the same clock and decide the state of one flag: an event pulse from the engine, and a processor access that clears that flag. The bench drives a start-of-frame pulse, and separately an activity strobe, in the same cycle as a read strobe to the control word. It also drives a bus-reset pulse in the same cycle as a write of zero to the reset-seen bit. Each case is judged by a second read, which must still show the flag set, and a third read, which must show it cleared.

// File: rtl/usbdev_pkg.sv
package usbdev_pkg;
  localparam int DATA_W    = 16;
  localparam int FRAME_W   = 11;
  localparam int DEVADDR_W = 7;

  // control word bit positions
  localparam int BIT_EN  = 0;
  localparam int BIT_RST = 1;
  localparam int BIT_SOF = 2;
  localparam int BIT_ACT = 3;

  // number of sticky event flags (reset, sof, activity)
  localparam int NUM_FLAGS = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_GLB  = 2'd1,
    SEL_FRM  = 2'd2,
    SEL_ADR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/usbdev_decode.sv
module usbdev_decode
  import usbdev_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC080
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] GLB_OFS = BASE_ADDR;
  localparam logic [ADDR_W-1:0] FRM_OFS = BASE_ADDR + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_OFS = BASE_ADDR + ADDR_W'(4);

  always_comb begin
    if (addr_i == GLB_OFS)      sel_o = SEL_GLB;
    else if (addr_i == FRM_OFS) sel_o = SEL_FRM;
    else if (addr_i == ADR_OFS) sel_o = SEL_ADR;
    else                        sel_o = SEL_NONE;
  end
endmodule

// File: rtl/usbdev_evt_flag.sv
module usbdev_evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority so that an event is never lost to a clear
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/usbdev_idle_timer.sv
module usbdev_idle_timer #(
  parameter int IDLE_CYCLES = 144000
) (
  input  logic clk,
  input  logic rst,
  input  logic activity_i,
  output logic suspend_o
);
  localparam int             CW    = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0]  LIMIT = CW'(IDLE_CYCLES);
  localparam logic [CW-1:0]  LAST  = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      suspend_o <= 1'b0;
    end else if (activity_i) begin
      cnt_q     <= '0;
      suspend_o <= 1'b0;
    end else begin
      if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
      if (cnt_q == LAST)  suspend_o <= 1'b1;
    end
  end
endmodule

// File: rtl/usbdev_regs.sv
module usbdev_regs
  import usbdev_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC080,
  parameter int                CLK_KHZ   = 48000,
  parameter int                IDLE_US   = 3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata,
  input  logic              sof_pulse,
  input  logic [10:0]       sof_frame,
  input  logic              busrst_pulse,
  input  logic              activity_stb,
  output logic              usb_enable,
  output logic [6:0]        dev_addr,
  output logic              suspend_req
);
  localparam int IDLE_CYCLES = CLK_KHZ * IDLE_US / 1000;

  reg_sel_e               sel;
  logic                   glb_wr, glb_rd, adr_wr;
  logic [NUM_FLAGS-1:0]   flag_set, flag_clr, flag_q;
  logic [FRAME_W-1:0]     frame_q;
  logic [DEVADDR_W-1:0]   addr_q;
  logic                   en_q;
  logic [DATA_W-1:0]      rd_mux;
  logic                   unused_wdata;

  assign unused_wdata = ^cpu_wdata[DATA_W-1:DEVADDR_W];

  usbdev_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr_i(cpu_addr),
    .sel_o (sel)
  );

  assign glb_wr = cpu_wr && (sel == SEL_GLB);
  assign glb_rd = cpu_rd && (sel == SEL_GLB);
  assign adr_wr = cpu_wr && (sel == SEL_ADR);

  // flag 0: reset-seen, flag 1: sof-seen, flag 2: activity-seen
  assign flag_set = {activity_stb, sof_pulse, busrst_pulse};
  assign flag_clr = {glb_rd, glb_rd, glb_wr && !cpu_wdata[BIT_RST]};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    usbdev_evt_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (flag_set[g]),
      .clr_i (flag_clr[g]),
      .flag_o(flag_q[g])
    );
  end

  usbdev_idle_timer #(
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_idle (
    .clk       (clk),
    .rst       (rst),
    .activity_i(activity_stb),
    .suspend_o (suspend_req)
  );

  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (glb_wr) en_q <= cpu_wdata[BIT_EN];
  end

  always_ff @(posedge clk) begin
    if (rst)            frame_q <= '0;
    else if (sof_pulse) frame_q <= sof_frame;
  end

  always_ff @(posedge clk) begin
    if (rst)               addr_q <= '0;
    else if (busrst_pulse) addr_q <= '0;
    else if (adr_wr)       addr_q <= cpu_wdata[DEVADDR_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_GLB: begin
        rd_mux[BIT_EN]  = en_q;
        rd_mux[BIT_RST] = flag_q[0];
        rd_mux[BIT_SOF] = flag_q[1];
        rd_mux[BIT_ACT] = flag_q[2];
      end
      SEL_FRM: rd_mux[FRAME_W-1:0]   = frame_q;
      SEL_ADR: rd_mux[DEVADDR_W-1:0] = addr_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_rd) cpu_rdata <= rd_mux;
  end

  assign usb_enable = en_q;
  assign dev_addr   = addr_q;
endmodule

// File: rtl/usbdev_regs_chk.sv
module usbdev_regs_chk #(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'hC080,
  parameter int                IDLE_CYCLES = 144000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              wd_en,
  input logic [15:0]       cpu_rdata,
  input logic              sof_pulse,
  input logic [10:0]       sof_frame,
  input logic              busrst_pulse,
  input logic              activity_stb,
  input logic              usb_enable,
  input logic [6:0]        dev_addr,
  input logic              suspend_req,
  input logic [2:0]        flag_q,
  input logic [10:0]       frame_q
);
  localparam int            CW    = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic hit_glb, hit_adr;
  assign hit_glb = (cpu_addr == BASE_ADDR);
  assign hit_adr = (cpu_addr == BASE_ADDR + ADDR_W'(4));

  logic [CW-1:0] idle_cnt;
  always_ff @(posedge clk) begin
    if (rst || activity_stb)  idle_cnt <= '0;
    else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + CW'(1);
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && hit_glb) |=> (cpu_rdata[15:4] == 12'd0)); // R2
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && hit_glb) |=> (usb_enable == $past(wd_en))); // R2
  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |=> (frame_q == $past(sof_frame))); // R3
  AST_SOF_SET: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |=> flag_q[1]); // R6
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && hit_glb && !sof_pulse) |=> !flag_q[1]); // R5
  AST_RST_SET: assert property (@(posedge clk) disable iff (rst)
    busrst_pulse |=> flag_q[0]); // R7
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sof_pulse |=> $stable(frame_q)); // R8
  AST_ADDR_HI: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && hit_adr) |=> (cpu_rdata[15:7] == 9'd0)); // R9
  AST_ADDR_CLR: assert property (@(posedge clk) disable iff (rst)
    busrst_pulse |=> (dev_addr == 7'd0)); // R10
  AST_EN_KEEP: assert property (@(posedge clk) disable iff (rst)
    (busrst_pulse && !(cpu_wr && hit_glb)) |=> $stable(usb_enable)); // R10
  AST_SUSP_DROP: assert property (@(posedge clk) disable iff (rst)
    activity_stb |=> !suspend_req); // R11
  AST_SUSP_RISE: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt == LIMIT) |-> suspend_req); // R11
  AST_SUSP_EARLY: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt != LIMIT) |-> !suspend_req); // R11
  AST_ACT_SET: assert property (@(posedge clk) disable iff (rst)
    activity_stb |=> flag_q[2]); // R12
endmodule

bind usbdev_regs usbdev_regs_chk #(
  .ADDR_W     (ADDR_W),
  .BASE_ADDR  (BASE_ADDR),
  .IDLE_CYCLES(IDLE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_addr    (cpu_addr),
  .cpu_wr      (cpu_wr),
  .cpu_rd      (cpu_rd),
  .wd_en       (cpu_wdata[0]),
  .cpu_rdata   (cpu_rdata),
  .sof_pulse   (sof_pulse),
  .sof_frame   (sof_frame),
  .busrst_pulse(busrst_pulse),
  .activity_stb(activity_stb),
  .usb_enable  (usb_enable),
  .dev_addr    (dev_addr),
  .suspend_req (suspend_req),
  .flag_q      (flag_q),
  .frame_q     (frame_q)
);

// File: tb/sim_usbdev_regs.sv
`timescale 1ns/1ps
module sim_usbdev_regs;
  localparam logic [15:0] BASE = 16'hC080;
  localparam int          IDLE = 100; // 50000 kHz * 2 us / 1000

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        sof_pulse = 1'b0;
  logic [10:0] sof_frame = '0;
  logic        busrst_pulse = 1'b0;
  logic        activity_stb = 1'b0;
  logic        usb_enable;
  logic [6:0]  dev_addr;
  logic        suspend_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  usbdev_regs #(
    .ADDR_W(16), .BASE_ADDR(BASE), .CLK_KHZ(50000), .IDLE_US(2)
  ) u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sof_pulse(sof_pulse), .sof_frame(sof_frame),
    .busrst_pulse(busrst_pulse), .activity_stb(activity_stb),
    .usb_enable(usb_enable), .dev_addr(dev_addr), .suspend_req(suspend_req)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 enable", {15'd0, usb_enable}, 16'd0);
    chk("R1 addr", {9'd0, dev_addr}, 16'd0);
    chk("R1 suspend", {15'd0, suspend_req}, 16'd0);
    bus_read(BASE, d);        chk("R1 ctrl", d, 16'h0000);
    bus_read(BASE + 16'd2, d); chk("R1 frame", d, 16'h0000);
    bus_read(BASE + 16'd4, d); chk("R1 devaddr", d, 16'h0000);
  endtask

  task automatic t_enable;
    logic [15:0] d;
    bus_write(BASE, 16'hFFF3);
    chk("R2 enable out", {15'd0, usb_enable}, 16'd1);
    bus_read(BASE, d); chk("R2 reserved zero, R7 write1 no effect", d, 16'h0001);
  endtask

  task automatic t_sof;
    logic [15:0] d;
    @(negedge clk); sof_pulse = 1'b1; sof_frame = 11'h5A3;
    @(negedge clk); sof_pulse = 1'b0;
    bus_read(BASE + 16'd2, d); chk("R3 frame", d, 16'h05A3);
    bus_read(BASE, d);         chk("R3 sof flag", d, 16'h0005);
    bus_read(BASE, d);         chk("R5 sof cleared", d, 16'h0001);
    bus_write(BASE + 16'd2, 16'hFFFF);
    bus_read(BASE + 16'd2, d); chk("R8 frame read-only", d, 16'h05A3);
  endtask

  task automatic t_addr;
    logic [15:0] d;
    bus_write(BASE + 16'd4, 16'hFFFF);
    bus_read(BASE + 16'd4, d); chk("R9 addr upper zero", d, 16'h007F);
    bus_write(BASE + 16'd4, 16'h0025);
    bus_read(BASE + 16'd4, d); chk("R9 addr", d, 16'h0025);
    chk("R9 dev_addr out", {9'd0, dev_addr}, 16'h0025);
  endtask

  task automatic t_busrst;
    logic [15:0] d;
    @(negedge clk); busrst_pulse = 1'b1;
    @(negedge clk); busrst_pulse = 1'b0;
    chk("R10 addr cleared", {9'd0, dev_addr}, 16'd0);
    chk("R10 enable kept", {15'd0, usb_enable}, 16'd1);
    bus_read(BASE, d); chk("R7 reset flag", d, 16'h0003);
    bus_read(BASE, d); chk("R7 not cleared by read", d, 16'h0003);
    bus_write(BASE, 16'h0003);
    bus_read(BASE, d); chk("R7 write 1 no effect", d, 16'h0003);
    bus_write(BASE, 16'h0001);
    bus_read(BASE, d); chk("R7 write 0 clears", d, 16'h0001);
  endtask

  task automatic t_activity;
    logic [15:0] d;
    @(negedge clk); activity_stb = 1'b1;
    @(negedge clk); activity_stb = 1'b0;
    bus_read(BASE, d); chk("R12 activity flag", d, 16'h0009);
    bus_read(BASE, d); chk("R5 activity cleared", d, 16'h0001);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    // SOF and activity land on the clearing read
    @(negedge clk); cpu_addr = BASE; cpu_rd = 1'b1;
    sof_pulse = 1'b1; activity_stb = 1'b1; sof_frame = 11'h007;
    @(negedge clk); cpu_rd = 1'b0; sof_pulse = 1'b0; activity_stb = 1'b0;
    d = cpu_rdata; chk("R6 pre-read value", d, 16'h0001);
    bus_read(BASE, d); chk("R6 flags survive read", d, 16'h000D);
    bus_read(BASE, d); chk("R5 flags cleared later", d, 16'h0001);
    // bus reset lands on a clearing write
    @(negedge clk); cpu_addr = BASE; cpu_wdata = 16'h0001; cpu_wr = 1'b1;
    busrst_pulse = 1'b1;
    @(negedge clk); cpu_wr = 1'b0; busrst_pulse = 1'b0;
    bus_read(BASE, d); chk("R6 reset flag survives write", d, 16'h0003);
    bus_write(BASE, 16'h0001);
    bus_read(BASE, d); chk("R7 cleared afterwards", d, 16'h0001);
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    bus_read(BASE + 16'd6, d); chk("R4 unmapped", d, 16'h0000);
    bus_read(16'h0000, d);     chk("R4 unmapped low", d, 16'h0000);
  endtask

  task automatic t_idle;
    @(negedge clk); activity_stb = 1'b1;
    @(negedge clk); activity_stb = 1'b0;
    repeat (IDLE - 1) @(negedge clk);
    chk("R11 not yet suspended", {15'd0, suspend_req}, 16'd0);
    @(negedge clk);
    chk("R11 suspend raised", {15'd0, suspend_req}, 16'd1);
    repeat (20) @(negedge clk);
    chk("R11 suspend held", {15'd0, suspend_req}, 16'd1);
    activity_stb = 1'b1;
    @(negedge clk); activity_stb = 1'b0;
    chk("R11 suspend dropped", {15'd0, suspend_req}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_sof();
    t_addr();
    t_busrst();
    t_activity();
    t_collide();
    t_unmapped();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule